// File: doc/BRIEF.md
# Multiplexed SAR Converter Sequencer

This block drives an external 8-bit successive-approximation converter that has an eight-way analog input selector. A user asks for a conversion by pulsing a request together with a 3-bit channel number. The block puts the channel on the three select lines and strobes the address latch. It then strobes the start line and follows the converter's end-of-conversion line as it goes low and then high again. Next it raises output-enable, samples the converter's data bus into a result register and presents the result for one cycle, tagged with its channel.

The converter clock is made inside the block by dividing the system clock. End-of-conversion comes from the converter's slower clock domain, so it passes through a flop synchronizer before the sequencer reads it. Each wait on end-of-conversion has a limit counted in converter clocks. When a wait runs past the limit, the block raises an error pulse and goes back to idle. While a request is in progress, the block ignores any new requests.

Top module: `sar_mux_adc_ctrl`

## Requirements
- R1: While reset is held and right after it is released, busy, result-valid, error, address-latch, start and output-enable are all low.
- R2: A request seen while busy is low is accepted. Busy reads high from the next cycle. The select bus carries the requested channel, with bit 2 as the most significant select line and bit 0 as the least, from that cycle until busy falls, and it does not change in that time.
- R3: The address-latch strobe is high for exactly ALE_CYCLES system clocks. The start strobe follows directly after it, is high for exactly START_CYCLES system clocks, and rises only in the cycle after the address-latch strobe was high. The two strobes are never high together.
- R4: After the start strobe falls, the block waits for end-of-conversion to go low and then high. Output-enable rises exactly three system clocks after end-of-conversion rises: two synchronizer flops plus one state step.
- R5: Output-enable is high for exactly two system clocks, only while end-of-conversion is high, and never while busy is low. The data bus is sampled in the second of those cycles.
- R6: Result-valid is a single-cycle pulse. It carries the sampled data and the channel of the accepted request, and busy is low in the next cycle.
- R7: A request that arrives while busy is high has no effect. It produces no extra result, and the result carries the channel of the first request.
- R8: Conversions that keep end-of-conversion low for 64 or 72 converter clocks finish normally, with no error.
- R9: If end-of-conversion never goes low after start, the error output pulses for one cycle. This happens between 79 and 82 converter-clock periods after start falls. Busy is low in that same cycle, and no result is produced.
- R10: If end-of-conversion goes low but never returns high, the same error behaviour as R9 applies, measured from start falling. Afterwards a new request completes normally.
- R11: The converter clock has a period of 2*CLK_HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Conversion request strobe |
| req_chan | input | 3 | Channel for the request |
| busy | output | 1 | A request is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 8 | Converted value |
| res_chan | output | 3 | Channel the result belongs to |
| err | output | 1 | One-cycle end-of-conversion timeout pulse |
| cv_clk | output | 1 | Divided converter clock |
| cv_sel | output | 3 | Analog channel select lines |
| cv_ale | output | 1 | Address latch strobe |
| cv_start | output | 1 | Conversion start strobe |
| cv_eoc | input | 1 | End-of-conversion from the converter |
| cv_oe | output | 1 | Output enable to the converter |
| cv_data | input | 8 | Converter data bus |

## Verification
The hardest conditions to reach are the two timeout paths, because a working converter never produces them. The bench's behavioural converter model has a fault switch. With it set, the model either never pulls end-of-conversion low after start, or pulls it low and holds it there. The bench then measures the error pulse against the converter-clock window. The model also responds with both 64-clock and 72-clock conversion lengths, which shows that the longest legal conversion stays inside the limit. Finally, the bench injects a request in the middle of a conversion to check that it is ignored.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SET_ADDR,
        ST_ALE,
        ST_START,
        ST_EOC_LO,
        ST_EOC_HI,
        ST_OE,
        ST_CAPTURE,
        ST_DONE
    } sarc_state_e;

endpackage

// File: rtl/sarc_clkdiv.sv
module sarc_clkdiv #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic cv_clk_o,
    output logic rise_o
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          lvl;
    } div_t;

    div_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == DW'(HALF - 1)) begin
            d.cnt = '0;
            d.lvl = ~q.lvl;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cv_clk_o = q.lvl;
    assign rise_o   = (q.cnt == DW'(HALF - 1)) && !q.lvl;
endmodule

// File: rtl/sarc_sync.sv
module sarc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RST_VAL;
                    else        chain_q[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RST_VAL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sarc_tmo.sv
module sarc_tmo #(
    parameter int LIMIT = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == TW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                          cnt_d = '0;
        else if (run && tick && !expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sar_mux_adc_ctrl.sv
module sar_mux_adc_ctrl
    import sarc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CH_W        = 3,
    parameter int CLK_HALF    = 2,
    parameter int ALE_CYCLES  = 3,
    parameter int START_CYCLES = 2,
    parameter int TMO_CLKS    = 80,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    output logic              busy,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [CH_W-1:0]   res_chan,
    output logic              err,
    output logic              cv_clk,
    output logic [CH_W-1:0]   cv_sel,
    output logic              cv_ale,
    output logic              cv_start,
    input  logic              cv_eoc,
    output logic              cv_oe,
    input  logic [DATA_W-1:0] cv_data
);
    localparam int PMAX = (ALE_CYCLES > START_CYCLES) ? ALE_CYCLES : START_CYCLES;
    localparam int PW   = $clog2(PMAX + 1);

    typedef struct packed {
        sarc_state_e       st;
        logic [PW-1:0]     pcnt;
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] res;
        logic              vld;
        logic              err;
    } ctl_t;

    ctl_t q, d;
    logic cv_tick, eoc_s, tmo_clr, tmo_run, tmo_exp;

    sarc_clkdiv #(.HALF(CLK_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .cv_clk_o(cv_clk), .rise_o(cv_tick)
    );

    sarc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cv_eoc), .dout(eoc_s)
    );

    sarc_tmo #(.LIMIT(TMO_CLKS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .run(tmo_run),
        .tick(cv_tick), .expired(tmo_exp)
    );

    assign tmo_run = (q.st == ST_EOC_LO) || (q.st == ST_EOC_HI);

    always_comb begin
        d       = q;
        d.vld   = 1'b0;
        d.err   = 1'b0;
        tmo_clr = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.ch = req_chan;
                    d.st = ST_SET_ADDR;
                end
            end
            ST_SET_ADDR: begin
                d.pcnt = PW'(ALE_CYCLES - 1);
                d.st   = ST_ALE;
            end
            ST_ALE: begin
                if (q.pcnt == '0) begin
                    d.pcnt = PW'(START_CYCLES - 1);
                    d.st   = ST_START;
                end else begin
                    d.pcnt = q.pcnt - 1'b1;
                end
            end
            ST_START: begin
                if (q.pcnt == '0) begin
                    tmo_clr = 1'b1;
                    d.st    = ST_EOC_LO;
                end else begin
                    d.pcnt = q.pcnt - 1'b1;
                end
            end
            ST_EOC_LO: begin
                if (!eoc_s) begin
                    tmo_clr = 1'b1;
                    d.st    = ST_EOC_HI;
                end else if (tmo_exp) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_EOC_HI: begin
                if (eoc_s) begin
                    d.st = ST_OE;
                end else if (tmo_exp) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_OE: d.st = ST_CAPTURE;
            ST_CAPTURE: begin
                d.res = cv_data;
                d.vld = 1'b1;
                d.st  = ST_DONE;
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign res_valid = q.vld;
    assign res_data  = q.res;
    assign res_chan  = q.ch;
    assign err       = q.err;
    assign cv_sel    = q.ch;
    assign cv_ale    = (q.st == ST_ALE);
    assign cv_start  = (q.st == ST_START);
    assign cv_oe     = (q.st == ST_OE) || (q.st == ST_CAPTURE);
endmodule

// File: rtl/sarc_ctrl_sva.sv
module sarc_ctrl_sva #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            res_valid,
    input logic            err,
    input logic            cv_ale,
    input logic            cv_start,
    input logic            cv_oe,
    input logic [CH_W-1:0] cv_sel
);
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cv_ale && cv_start)); // R3
    AST_START_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cv_start) |-> $past(cv_ale)); // R3
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(cv_sel)); // R2
    AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !cv_oe); // R5
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R6
    AST_IDLE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !busy); // R6
    AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!res_valid && !busy)); // R9
endmodule

bind sar_mux_adc_ctrl sarc_ctrl_sva #(.CH_W(CH_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .busy(busy), .res_valid(res_valid), .err(err),
    .cv_ale(cv_ale), .cv_start(cv_start), .cv_oe(cv_oe), .cv_sel(cv_sel)
);

// File: tb/sar_mux_adc_ctrl_test.sv
`timescale 1ns/1ps
module sar_mux_adc_ctrl_test;
    localparam int HALF = 2;
    localparam int P    = 2 * HALF;
    localparam int ALEW = 3;
    localparam int STW  = 2;
    localparam int TMO  = 80;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [2:0] req_chan = 0;
    logic busy, res_valid, err, cv_clk, cv_ale, cv_start, cv_oe;
    logic [7:0] res_data, cv_data;
    logic [2:0] res_chan, cv_sel;
    logic cv_eoc = 1;

    int n_checks = 0, n_fail = 0;
    int conv_len = 64, fault = 0, nconv = 0;
    logic [7:0] out_latch = 0;
    logic [2:0] ch_lat = 0;

    always #4 clk = ~clk;

    sar_mux_adc_ctrl #(.CLK_HALF(HALF), .ALE_CYCLES(ALEW), .START_CYCLES(STW), .TMO_CLKS(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan), .busy(busy),
        .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan), .err(err),
        .cv_clk(cv_clk), .cv_sel(cv_sel), .cv_ale(cv_ale), .cv_start(cv_start),
        .cv_eoc(cv_eoc), .cv_oe(cv_oe), .cv_data(cv_data)
    );

    // behavioural converter
    assign cv_data = cv_oe ? out_latch : 8'hEE;
    always @(negedge cv_ale) ch_lat = cv_sel;
    always begin
        @(negedge cv_start);
        if (fault != 1) begin
            @(posedge cv_clk);
            cv_eoc = 0;
            if (fault == 2) begin
                wait (fault == 0);
                cv_eoc = 1;
            end else begin
                repeat (conv_len) @(posedge cv_clk);
                nconv++;
                out_latch = 8'(ch_lat * 37 + nconv * 11);
                cv_eoc = 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // edge-captured inputs
    logic req_e = 0, busy_e = 0;
    logic [2:0] chan_e = 0;
    always @(posedge clk) begin
        req_e  <= req_valid;
        busy_e <= busy;
        chan_e <= req_chan;
    end

    // every-clock reference model
    int cyc = 0, ale_w = 0, st_w = 0, oe_w = 0, eoc_rise = -100, clk_rise = -1;
    int start_fall = 0, err_cyc = 0, n_res = 0, n_err = 0;
    bit exp_busy = 0, vld_prev = 0, ale_p = 0, st_p = 0, oe_p = 0, eoc_p = 1, ck_p = 0;
    logic [2:0] cur_ch = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (req_e && !busy_e) begin exp_busy = 1; cur_ch = chan_e; end
            if (vld_prev) exp_busy = 0;
            if (err) exp_busy = 0;
            check(busy == exp_busy, "R2/R7 busy", busy, exp_busy);
            if (busy) check(cv_sel == cur_ch, "R2 select", cv_sel, cur_ch);
            if (cv_ale) ale_w++;
            else if (ale_p) begin check(ale_w == ALEW, "R3 ale width", ale_w, ALEW); ale_w = 0; end
            if (cv_start) begin
                if (!st_p) check(ale_p, "R3 start after ale", ale_p, 1);
                check(!cv_ale, "R3 overlap", cv_ale, 0);
                st_w++;
            end else if (st_p) begin
                check(st_w == STW, "R3 start width", st_w, STW);
                st_w = 0; start_fall = cyc;
            end
            if (cv_eoc && !eoc_p) eoc_rise = cyc;
            if (cv_oe) begin
                check(cv_eoc, "R5 oe needs eoc high", cv_eoc, 1);
                if (!oe_p) check(cyc - eoc_rise == 3, "R4 oe delay", cyc - eoc_rise, 3);
                oe_w++;
            end else if (oe_p) begin
                check(oe_w == 2, "R5 oe width", oe_w, 2); oe_w = 0;
            end
            if (!busy) check(!cv_oe, "R5 oe idle", cv_oe, 0);
            if (res_valid) begin
                n_res++;
                check(fault == 0, "R9/R10 result on fault", 1, 0);
                check(res_chan == cur_ch, "R6/R7 res chan", res_chan, cur_ch);
                check(res_data == out_latch, "R6 res data", res_data, out_latch);
                check(!vld_prev, "R6 single pulse", vld_prev, 0);
            end
            if (err) begin n_err++; err_cyc = cyc; end
            if (cv_clk && !ck_p) begin
                if (clk_rise >= 0) check(cyc - clk_rise == P, "R11 clk period", cyc - clk_rise, P);
                clk_rise = cyc;
            end
        end
        vld_prev = res_valid; ale_p = cv_ale; st_p = cv_start; oe_p = cv_oe;
        eoc_p = cv_eoc; ck_p = cv_clk;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) if (cyc == 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic run(input logic [2:0] ch, input int len, input bit poke, output bit got_err);
        int r0, e0;
        r0 = n_res; e0 = n_err; got_err = 0;
        while (busy) @(negedge clk);
        conv_len = len;
        req_valid = 1; req_chan = ch;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            repeat (20) @(negedge clk);
            req_valid = 1; req_chan = ~ch;
            @(negedge clk);
            req_valid = 0;
        end
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (n_res != r0 || n_err != e0) break;
        end
        repeat (3) @(negedge clk);
        got_err = (n_err != e0);
        check(!busy, "R6 idle after", busy, 0);
        if (fault == 0) begin
            check(n_res - r0 == 1, poke ? "R7 one result" : "R8 one result", n_res - r0, 1);
            check(!got_err, "R8 no error", got_err, 0);
        end
    endtask

    initial begin
        bit ge;
        repeat (3) @(negedge clk);
        check(!busy && !res_valid && !err && !cv_ale && !cv_start && !cv_oe, "R1 in reset", busy, 0);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !res_valid && !err && !cv_ale && !cv_start && !cv_oe, "R1 after reset", busy, 0);
        for (int c = 0; c < 8; c++) run(3'(c), 64, 0, ge);
        run(3'd5, 72, 0, ge);
        run(3'd2, 64, 1, ge);
        fault = 1;
        run(3'd3, 64, 0, ge);
        check(ge, "R9 error pulse", ge, 1);
        check(err_cyc - start_fall >= 79 * P && err_cyc - start_fall <= 82 * P + 4,
              "R9 window", err_cyc - start_fall, 80 * P);
        fault = 0;
        repeat (5) @(negedge clk);
        fault = 2;
        run(3'd6, 64, 0, ge);
        check(ge, "R10 error pulse", ge, 1);
        check(err_cyc - start_fall >= 79 * P && err_cyc - start_fall <= 83 * P + 4,
              "R10 window", err_cyc - start_fall, 81 * P);
        fault = 0;
        repeat (10) @(negedge clk);
        run(3'd1, 64, 0, ge);
        summary();
    end
endmodule